// File: doc/BRIEF.md
# Link Pulse Remote Status Codec

This block carries a small amount of status between the two ends of a twisted-pair link using only the spacing of link integrity pulses. On the transmit side it emits a one-cycle pulse strobe after a chosen number of millisecond ticks. The gaps between strobes form a repeating pattern that depends on the local condition. With no fault, the pattern is short, long, and only advertises that this end can signal. With a link failure the pattern is short, medium, long. With a jabber condition it is short, long, medium. The nominal gaps are 10, 15 and 20 ms.

On the receive side the block counts ticks between incoming pulse strobes and sorts each gap into short, medium, long or invalid. It follows the order of the gaps and raises one of three remote status outputs when a full pattern has been seen. Each output holds until a different pattern is decoded or the link goes quiet.

Top module: `lpsc_codec`

## Requirements
- R1: With both local status inputs low, the gaps between `pulse_out` strobes repeat as 10, 20 ticks.
- R2: With `loc_link_down` high and `loc_jabber` low, the gaps repeat as 10, 15, 20 ticks.
- R3: With `loc_jabber` high, the gaps repeat as 10, 20, 15 ticks.
- R4: `loc_jabber` takes precedence over `loc_link_down`, which takes precedence over plain capability signalling.
- R5: The local status inputs are sampled on the first tick of each pattern. A change in the middle of a pattern takes effect only at the next pattern.
- R6: `pulse_out` is high for exactly one cycle, in the cycle after the tick that ends a gap. The first strobe comes 10 ticks after reset. Every gap lies between 8 and 24 ticks.
- R7: A received gap counts as 10, 15 or 20 when it is within 2 ticks of that value. Any other gap abandons the partial pattern and does not change the outputs.
- R8: Received gaps 10, 15, 20 in a row raise `rem_link_down` and clear the other two outputs, in the cycle after the third pulse.
- R9: Received gaps 10, 20, 15 raise `rem_jabber` and clear the other two outputs.
- R10: Received gaps 10, 20 raise `rem_compat` when the gap that follows is a 10. That 10 also starts the next pattern.
- R11: At most one remote output is high at a time. An output holds its value through partial or repeated patterns.
- R12: When 100 ticks pass with no `pulse_in`, all remote outputs clear on the 100th tick.
- R13: After reset, all remote outputs and `pulse_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle strobe each millisecond |
| loc_jabber | input | 1 | Local jabber condition |
| loc_link_down | input | 1 | Local link failure condition |
| pulse_in | input | 1 | One-cycle strobe per received link pulse |
| pulse_out | output | 1 | One-cycle strobe per link pulse to send |
| rem_link_down | output | 1 | Remote end reports link failure |
| rem_jabber | output | 1 | Remote end reports jabber |
| rem_compat | output | 1 | Remote end can signal status |

## Verification
The checks assume that `tick_1ms` and `pulse_in` are single-cycle strobes that never fall in the same cycle, and that at least one idle cycle separates any two ticks. The stimulus follows these rules: every tick is followed by two idle cycles, and a received pulse is always placed in a cycle of its own between ticks. Under these conditions the received gap equals the number of ticks the bench drives. The transmit gap equals the number of ticks counted before the strobe appears.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

    typedef enum logic [1:0] {SEQ_CAP, SEQ_LDN, SEQ_JAB} seq_e;
    typedef enum logic [1:0] {IV_BAD, IV_SHORT, IV_MID, IV_LONG} ivl_e;
    typedef enum logic [1:0] {MS_IDLE, MS_S, MS_SM, MS_SL} mst_e;
    typedef enum logic [1:0] {RS_NONE, RS_LDN, RS_JAB, RS_CAP} rstat_e;

    // Jabber wins over link-down, link-down over plain capability.
    function automatic seq_e pick_seq(input logic jab, input logic ldn);
        if (jab)      return SEQ_JAB;
        else if (ldn) return SEQ_LDN;
        else          return SEQ_CAP;
    endfunction

    function automatic logic [1:0] seq_last(input seq_e s);
        return (s == SEQ_CAP) ? 2'd1 : 2'd2;
    endfunction

    // Interval class for position idx of pattern s.
    function automatic ivl_e seq_step(input seq_e s, input logic [1:0] idx);
        case (idx)
            2'd0:    return IV_SHORT;
            2'd1:    return (s == SEQ_LDN) ? IV_MID : IV_LONG;
            default: return (s == SEQ_LDN) ? IV_LONG : IV_MID;
        endcase
    endfunction

    function automatic ivl_e classify(input int g, input int s, input int m,
                                      input int l, input int tol);
        if (g >= s - tol && g <= s + tol)      return IV_SHORT;
        else if (g >= m - tol && g <= m + tol) return IV_MID;
        else if (g >= l - tol && g <= l + tol) return IV_LONG;
        else                                   return IV_BAD;
    endfunction

endpackage

// File: rtl/lpsc_tx_sched.sv
module lpsc_tx_sched
    import lpsc_pkg::*;
#(
    parameter int T_SHORT = 10,
    parameter int T_MID   = 15,
    parameter int T_LONG  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic loc_jab,
    input  logic loc_ldn,
    output logic pulse_out
);
    localparam int CW = $clog2(T_LONG + 1);
    localparam logic [CW:0] LIM_S = (CW+1)'(T_SHORT);
    localparam logic [CW:0] LIM_M = (CW+1)'(T_MID);
    localparam logic [CW:0] LIM_L = (CW+1)'(T_LONG);

    logic [CW-1:0] cnt;
    logic [1:0]    idx;
    seq_e          cur, seq_eff;
    logic          at_start, hit;
    logic [CW:0]   target;

    always_comb begin
        at_start = (idx == 2'd0) && (cnt == '0);
        seq_eff  = at_start ? pick_seq(loc_jab, loc_ldn) : cur;
        case (seq_step(seq_eff, idx))
            IV_MID:  target = LIM_M;
            IV_LONG: target = LIM_L;
            default: target = LIM_S;
        endcase
        hit = (({1'b0, cnt} + (CW+1)'(1)) == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            idx       <= 2'd0;
            cur       <= SEQ_CAP;
            pulse_out <= 1'b0;
        end else begin
            pulse_out <= 1'b0;
            if (tick) begin
                if (at_start) cur <= seq_eff;
                if (hit) begin
                    pulse_out <= 1'b1;
                    cnt       <= '0;
                    idx       <= (idx == seq_last(seq_eff)) ? 2'd0 : idx + 2'd1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/lpsc_rx_gap.sv
module lpsc_rx_gap
    import lpsc_pkg::*;
#(
    parameter int T_SHORT    = 10,
    parameter int T_MID      = 15,
    parameter int T_LONG     = 20,
    parameter int TOL        = 2,
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pulse_in,
    output ivl_e cls,
    output logic expire
);
    localparam int GW = $clog2(TIMEOUT_MS + 1);
    localparam logic [GW-1:0] GMAX = GW'(TIMEOUT_MS);

    logic [GW-1:0] gap;

    always_comb begin
        cls    = classify(int'(gap), T_SHORT, T_MID, T_LONG, TOL);
        expire = tick && !pulse_in && (gap == GMAX - GW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst)                         gap <= '0;
        else if (pulse_in)               gap <= '0;
        else if (tick && gap < GMAX)     gap <= gap + GW'(1);
    end
endmodule

// File: rtl/lpsc_seq_match.sv
module lpsc_seq_match
    import lpsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    input  ivl_e cls,
    input  logic expire,
    output logic rem_ldn,
    output logic rem_jab,
    output logic rem_cap
);
    mst_e   st, st_nx;
    rstat_e stat, stat_nx;

    always_comb begin
        st_nx   = st;
        stat_nx = stat;
        if (pulse_in) begin
            case (cls)
                IV_SHORT: begin
                    if (st == MS_SL) stat_nx = RS_CAP;
                    st_nx = MS_S;
                end
                IV_MID: begin
                    if (st == MS_S) st_nx = MS_SM;
                    else begin
                        if (st == MS_SL) stat_nx = RS_JAB;
                        st_nx = MS_IDLE;
                    end
                end
                IV_LONG: begin
                    if (st == MS_S) st_nx = MS_SL;
                    else begin
                        if (st == MS_SM) stat_nx = RS_LDN;
                        st_nx = MS_IDLE;
                    end
                end
                default: st_nx = MS_IDLE;
            endcase
        end else if (expire) begin
            st_nx   = MS_IDLE;
            stat_nx = RS_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= MS_IDLE;
            stat <= RS_NONE;
        end else begin
            st   <= st_nx;
            stat <= stat_nx;
        end
    end

    assign rem_ldn = (stat == RS_LDN);
    assign rem_jab = (stat == RS_JAB);
    assign rem_cap = (stat == RS_CAP);
endmodule

// File: rtl/lpsc_codec.sv
module lpsc_codec
    import lpsc_pkg::*;
#(
    parameter int T_SHORT    = 10,
    parameter int T_MID      = 15,
    parameter int T_LONG     = 20,
    parameter int TOL        = 2,
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_1ms,
    input  logic loc_jabber,
    input  logic loc_link_down,
    input  logic pulse_in,
    output logic pulse_out,
    output logic rem_link_down,
    output logic rem_jabber,
    output logic rem_compat
);
    ivl_e rx_cls;
    logic rx_expire;

    lpsc_tx_sched #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)) u_tx (
        .clk(clk), .rst(rst), .tick(tick_1ms),
        .loc_jab(loc_jabber), .loc_ldn(loc_link_down),
        .pulse_out(pulse_out)
    );

    lpsc_rx_gap #(.T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG),
                  .TOL(TOL), .TIMEOUT_MS(TIMEOUT_MS)) u_gap (
        .clk(clk), .rst(rst), .tick(tick_1ms), .pulse_in(pulse_in),
        .cls(rx_cls), .expire(rx_expire)
    );

    lpsc_seq_match u_match (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .cls(rx_cls), .expire(rx_expire),
        .rem_ldn(rem_link_down), .rem_jab(rem_jabber), .rem_cap(rem_compat)
    );
endmodule

// File: rtl/lpsc_codec_chk.sv
module lpsc_codec_chk (
    input logic clk,
    input logic rst,
    input logic tick_1ms,
    input logic pulse_in,
    input logic pulse_out,
    input logic rem_link_down,
    input logic rem_jabber,
    input logic rem_compat
);
    logic [7:0] tk_since;

    always_ff @(posedge clk) begin
        if (rst)            tk_since <= 8'd0;
        else if (pulse_out) tk_since <= tick_1ms ? 8'd1 : 8'd0;
        else if (tick_1ms && tk_since != 8'hFF) tk_since <= tk_since + 8'd1;
    end

    assert_single_status_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rem_link_down, rem_jabber, rem_compat}));

    assert_strobe_width_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_out |=> !pulse_out);

    assert_strobe_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(tick_1ms));

    assert_gap_window_R6: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> (tk_since >= 8'd8 && tk_since <= 8'd24));

    assert_rise_on_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(rem_link_down) || $rose(rem_jabber) || $rose(rem_compat)) |-> $past(pulse_in));

    assert_change_cause_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable({rem_link_down, rem_jabber, rem_compat}) |-> ($past(pulse_in) || $past(tick_1ms)));
endmodule

bind lpsc_codec lpsc_codec_chk u_chk (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .pulse_in(pulse_in),
    .pulse_out(pulse_out), .rem_link_down(rem_link_down),
    .rem_jabber(rem_jabber), .rem_compat(rem_compat)
);

// File: tb/tb_lpsc_codec.sv
module tb_lpsc_codec;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_1ms = 1'b0, loc_jabber = 1'b0, loc_link_down = 1'b0, pulse_in = 1'b0;
    logic pulse_out, rem_link_down, rem_jabber, rem_compat;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpsc_codec dut (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .loc_jabber(loc_jabber),
        .loc_link_down(loc_link_down), .pulse_in(pulse_in), .pulse_out(pulse_out),
        .rem_link_down(rem_link_down), .rem_jabber(rem_jabber), .rem_compat(rem_compat)
    );

    // Transmit rows: {jabber, link_down, expected gap in ticks}
    localparam logic [6:0] TX_TBL [16] = '{
        {2'b00, 5'd10}, {2'b00, 5'd20}, {2'b00, 5'd10}, {2'b00, 5'd20},   // R1 R13
        {2'b01, 5'd10}, {2'b01, 5'd15}, {2'b01, 5'd20},                   // R2
        {2'b11, 5'd10}, {2'b11, 5'd20}, {2'b11, 5'd15},                   // R3 R4
        {2'b10, 5'd10}, {2'b00, 5'd20}, {2'b00, 5'd15},                   // R5
        {2'b00, 5'd10}, {2'b00, 5'd20}, {2'b00, 5'd10}                    // R5
    };

    // Receive rows: {gap in ticks, expected {link_down, jabber, compat}}
    localparam logic [7:0] RX_TBL [26] = '{
        {5'd10, 3'b000}, {5'd15, 3'b000}, {5'd20, 3'b100},   // R8
        {5'd10, 3'b100}, {5'd20, 3'b100}, {5'd15, 3'b010},   // R11 R9
        {5'd10, 3'b010}, {5'd20, 3'b010}, {5'd10, 3'b001},   // R10
        {5'd20, 3'b001}, {5'd9,  3'b001}, {5'd22, 3'b001},   // R7 tolerance
        {5'd13, 3'b010}, {5'd12, 3'b010}, {5'd17, 3'b010},
        {5'd18, 3'b100}, {5'd10, 3'b100}, {5'd23, 3'b100},   // R7 bad gap
        {5'd15, 3'b100}, {5'd20, 3'b100}, {5'd10, 3'b100},
        {5'd20, 3'b100}, {5'd7,  3'b100}, {5'd10, 3'b100},
        {5'd20, 3'b100}, {5'd15, 3'b010}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tk(output logic seen);
        @(negedge clk) tick_1ms = 1'b1;
        @(negedge clk) tick_1ms = 1'b0;
        seen = pulse_out;
        @(negedge clk);
        if (seen) check("R6 width", int'(pulse_out), 0);
    endtask

    task automatic measure(output int n);
        logic seen;
        n = 0;
        do begin
            tk(seen);
            n++;
        end while (!seen && n < 40);
    endtask

    task automatic send_gap(input int g);
        logic seen;
        for (int i = 0; i < g; i++) tk(seen);
        @(negedge clk) pulse_in = 1'b1;
        @(negedge clk) pulse_in = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int n;
        logic seen;
        do_reset();
        check("R13 outputs", int'({rem_link_down, rem_jabber, rem_compat}), 0);
        check("R13 pulse_out", int'(pulse_out), 0);

        for (int i = 0; i < 16; i++) begin
            {loc_jabber, loc_link_down} = TX_TBL[i][6:5];
            measure(n);
            check($sformatf("R1-5 tx row %0d (R1 R2 R3 R4 R5)", i), n, int'(TX_TBL[i][4:0]));
        end
        loc_jabber = 1'b0;
        loc_link_down = 1'b0;

        do_reset();
        check("R13 after reset", int'({rem_link_down, rem_jabber, rem_compat}), 0);
        for (int i = 0; i < 26; i++) begin
            send_gap(int'(RX_TBL[i][7:3]));
            check($sformatf("rx row %0d (R7 R8 R9 R10 R11)", i),
                  int'({rem_link_down, rem_jabber, rem_compat}), int'(RX_TBL[i][2:0]));
        end

        for (int i = 0; i < 99; i++) tk(seen);
        check("R12 hold at 99", int'({rem_link_down, rem_jabber, rem_compat}), 3'b010);
        tk(seen);
        check("R12 clear at 100", int'({rem_link_down, rem_jabber, rem_compat}), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule